// File: doc/BRIEF.md
# Per-Processor Banked GPIO Interrupt Router

This block sits behind the polarity-corrected GPIO input lines of a bank and turns them into interrupts for up to four processors. Every processor owns a private set of three registers: an edge-cause register that latches input edge events, an edge-mask register and a level-mask register. A processor's pending lines are its masked edge causes together with the masked current line levels. Each group of eight adjacent lines is reduced to one summary interrupt per processor, so every processor sees its own group outputs and is never disturbed by another processor masking or acknowledging.

The registers live in a dedicated register window with a simple request interface: a one-cycle request with write enable, address and write data, and read data returned on the cycle after a read request. An edge event is broadcast to all banks at once. A processor acknowledges by writing a word with a zero in each bit to clear and ones elsewhere into its own cause register. This leaves every other bank's causes pending.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is asserted and on leaving it, every cause, edge-mask and level-mask register of every processor reads 0, every group output is 0 and the read data bus is 0.
- R2: In the window, processor n's cause register is at byte offset 4*n, its edge mask at 0x10 + 4*n and its level mask at 0x20 + 4*n. A read request with the valid address returns the register value on reg_rdata in the cycle after the request; in any cycle that does not follow a read request reg_rdata is 0.
- R3: A 1 on edge_evt bit i in a cycle sets bit i of every processor's cause register at the next clock edge.
- R4: A write to a processor's cause register clears the bits where the write data is 0 and keeps those where it is 1; the causes of every other processor are unchanged.
- R5: When an edge event on a line and a cause write clearing that same line happen in the same cycle, the cause bit ends up set.
- R6: A write to an edge-mask or level-mask register replaces the whole value of that one register; a mask holds its value in every cycle without a write to it.
- R7: Group output bit n*4+g (processor n, group g covering lines 8g..8g+7) is 1 one clock after a cycle in which any of those lines has (line_level AND level mask) OR (cause AND edge mask) set for processor n.
- R8: The level path does not latch: a level-triggered group output falls one cycle after the line returns to 0, and the cause register is not changed by line levels.
- R9: A request to an offset that is unaligned (low two bits non-zero) or at 0x30 or above reads 0 and a write to it changes no register.
- R10: A cause bit stays set while its edge mask is 0 and is readable, and the group output rises once the edge mask for that line is written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_level | input | 32 | Polarity-corrected input line levels |
| edge_evt | input | 32 | One-cycle edge event per line |
| reg_en | input | 1 | Register request valid |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset in the per-processor window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_grp | output | 16 | Group interrupts, bit n*4+g for processor n, group g |

## Verification
The bound checker watches, on every cycle, that edge events land in all four cause registers, that a cause bit only falls under a write to its own processor's cause offset, that masks only move on a write to their own offset, that a processor with both masks clear raises no group output, and that unused offsets and idle cycles give zero read data. The bench scenarios show what needs a history of operations: the exact cleared-bit pattern after an acknowledge, the set-over-clear priority in the same cycle, the non-latching level path, a masked cause staying readable and firing once unmasked, and the exact group outputs against a bench model over a long random mix of events, acknowledges, mask writes and level changes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register kind selected by offset bits [5:4] of the window.
    typedef enum logic [1:0] {
        KIND_CAUSE = 2'd0,
        KIND_EMASK = 2'd1,
        KIND_LMASK = 2'd2,
        KIND_NONE  = 2'd3
    } bank_kind_e;

    // A kind slot holds four 4-byte registers, one per processor.
    localparam int unsigned CPU_IDX_W   = 2;
    localparam int unsigned MAX_CPUS    = 4;
    localparam int unsigned WINDOW_BITS = 6;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_CPUS = 4
) (
    input  logic                 req_en,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    output bank_kind_e           req_kind,
    output logic [CPU_IDX_W-1:0] req_cpu,
    output logic                 rd_req,
    output logic [NUM_CPUS-1:0]  wr_cause,
    output logic [NUM_CPUS-1:0]  wr_emask,
    output logic [NUM_CPUS-1:0]  wr_lmask
);

    logic       in_window;
    logic       aligned;
    logic       cpu_ok;
    logic       hit;
    logic [1:0] kind_raw;

    always_comb begin
        in_window = (req_addr >> WINDOW_BITS) == '0;
        aligned   = req_addr[1:0] == 2'b00;
        kind_raw  = req_addr[5:4];
        req_cpu   = req_addr[3:2];
        cpu_ok    = 32'(req_cpu) < NUM_CPUS;
        hit       = in_window && aligned && cpu_ok && (kind_raw != 2'd3);
        req_kind  = hit ? bank_kind_e'(kind_raw) : KIND_NONE;
        rd_req    = req_en && !req_we && hit;
        for (int n = 0; n < NUM_CPUS; n++) begin
            wr_cause[n] = req_en && req_we && (req_kind == KIND_CAUSE) && (req_cpu == CPU_IDX_W'(n));
            wr_emask[n] = req_en && req_we && (req_kind == KIND_EMASK) && (req_cpu == CPU_IDX_W'(n));
            wr_lmask[n] = req_en && req_we && (req_kind == KIND_LMASK) && (req_cpu == CPU_IDX_W'(n));
        end
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned GROUP_SIZE = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LINES-1:0]              line_level,
    input  logic [NUM_LINES-1:0]              edge_evt,
    input  logic                              wr_cause,
    input  logic                              wr_emask,
    input  logic                              wr_lmask,
    input  logic [NUM_LINES-1:0]              wdata,
    output logic [NUM_LINES-1:0]              cause_q,
    output logic [NUM_LINES-1:0]              emask_q,
    output logic [NUM_LINES-1:0]              lmask_q,
    output logic [NUM_LINES/GROUP_SIZE-1:0]   irq_q
);

    localparam int unsigned NUM_GROUPS = NUM_LINES / GROUP_SIZE;

    typedef struct packed {
        logic [NUM_LINES-1:0]  cause;
        logic [NUM_LINES-1:0]  emask;
        logic [NUM_LINES-1:0]  lmask;
        logic [NUM_GROUPS-1:0] irq;
    } bank_state_t;

    bank_state_t          st_d, st_q;
    logic [NUM_LINES-1:0] pending;

    always_comb begin
        st_d = st_q;
        // acknowledge: zero bits clear, one bits keep
        if (wr_cause) begin
            st_d.cause = st_q.cause & wdata;
        end
        // a new event in the same cycle wins over the clear
        st_d.cause = st_d.cause | edge_evt;
        if (wr_emask) begin
            st_d.emask = wdata;
        end
        if (wr_lmask) begin
            st_d.lmask = wdata;
        end
        pending = (line_level & st_q.lmask) | (st_q.cause & st_q.emask);
        for (int g = 0; g < NUM_GROUPS; g++) begin
            st_d.irq[g] = |pending[g*GROUP_SIZE +: GROUP_SIZE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_q = st_q.cause;
    assign emask_q = st_q.emask;
    assign lmask_q = st_q.lmask;
    assign irq_q   = st_q.irq;

endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned NUM_CPUS  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd_req,
    input  bank_kind_e                          rd_kind,
    input  logic [CPU_IDX_W-1:0]                rd_cpu,
    input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  cause_all,
    input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  emask_all,
    input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  lmask_all,
    output logic [NUM_LINES-1:0]                rdata_q
);

    logic [NUM_LINES-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        if (rd_req) begin
            unique case (rd_kind)
                KIND_CAUSE: rdata_d = cause_all[rd_cpu];
                KIND_EMASK: rdata_d = emask_all[rd_cpu];
                KIND_LMASK: rdata_d = lmask_all[rd_cpu];
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned NUM_CPUS   = 4,
    parameter int unsigned GROUP_SIZE = 8,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [NUM_LINES-1:0]                     line_level,
    input  logic [NUM_LINES-1:0]                     edge_evt,
    input  logic                                     reg_en,
    input  logic                                     reg_we,
    input  logic [ADDR_W-1:0]                        reg_addr,
    input  logic [NUM_LINES-1:0]                     reg_wdata,
    output logic [NUM_LINES-1:0]                     reg_rdata,
    output logic [NUM_CPUS*(NUM_LINES/GROUP_SIZE)-1:0] irq_grp
);

    localparam int unsigned NUM_GROUPS = NUM_LINES / GROUP_SIZE;

    bank_kind_e                          req_kind;
    logic [CPU_IDX_W-1:0]                req_cpu;
    logic                                rd_req;
    logic [NUM_CPUS-1:0]                 wr_cause;
    logic [NUM_CPUS-1:0]                 wr_emask;
    logic [NUM_CPUS-1:0]                 wr_lmask;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0]  cause_all;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0]  emask_all;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0]  lmask_all;

    gpio_irq_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CPUS (NUM_CPUS)
    ) u_decode (
        .req_en   (reg_en),
        .req_we   (reg_we),
        .req_addr (reg_addr),
        .req_kind (req_kind),
        .req_cpu  (req_cpu),
        .rd_req   (rd_req),
        .wr_cause (wr_cause),
        .wr_emask (wr_emask),
        .wr_lmask (wr_lmask)
    );

    for (genvar n = 0; n < NUM_CPUS; n++) begin : g_bank
        gpio_irq_bank #(
            .NUM_LINES  (NUM_LINES),
            .GROUP_SIZE (GROUP_SIZE)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_level (line_level),
            .edge_evt   (edge_evt),
            .wr_cause   (wr_cause[n]),
            .wr_emask   (wr_emask[n]),
            .wr_lmask   (wr_lmask[n]),
            .wdata      (reg_wdata),
            .cause_q    (cause_all[n]),
            .emask_q    (emask_all[n]),
            .lmask_q    (lmask_all[n]),
            .irq_q      (irq_grp[n*NUM_GROUPS +: NUM_GROUPS])
        );
    end

    gpio_irq_rdmux #(
        .NUM_LINES (NUM_LINES),
        .NUM_CPUS  (NUM_CPUS)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_kind   (req_kind),
        .rd_cpu    (req_cpu),
        .cause_all (cause_all),
        .emask_all (emask_all),
        .lmask_all (lmask_all),
        .rdata_q   (reg_rdata)
    );

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned NUM_CPUS   = 4,
    parameter int unsigned GROUP_SIZE = 8,
    parameter int unsigned ADDR_W     = 8
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic [NUM_LINES-1:0]                       edge_evt,
    input logic                                       reg_en,
    input logic                                       reg_we,
    input logic [ADDR_W-1:0]                          reg_addr,
    input logic [NUM_LINES-1:0]                       reg_rdata,
    input logic [NUM_CPUS*(NUM_LINES/GROUP_SIZE)-1:0] irq_grp,
    input logic [NUM_CPUS-1:0][NUM_LINES-1:0]         cause_all,
    input logic [NUM_CPUS-1:0][NUM_LINES-1:0]         emask_all,
    input logic [NUM_CPUS-1:0][NUM_LINES-1:0]         lmask_all
);

    localparam int unsigned NG = NUM_LINES / GROUP_SIZE;

    logic is_read;
    logic unused_off;

    assign is_read    = reg_en && !reg_we;
    assign unused_off = (reg_addr[1:0] != 2'b00) || (reg_addr >= ADDR_W'(48))
                        || (32'(reg_addr[3:2]) >= NUM_CPUS);

    // R1: group outputs are quiet right after any reset cycle
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_grp == '0));

    // R2: read data is zero when no read was requested
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> (reg_rdata == '0));

    // R9: unused offsets read as zero
    p_unused_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && unused_off) |=> (reg_rdata == '0));

    for (genvar n = 0; n < NUM_CPUS; n++) begin : g_cpu
        // R3: every bank latches each broadcast edge event
        p_evt_sets_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_evt != '0) |=> ((cause_all[n] & $past(edge_evt)) == $past(edge_evt)));

        // R4: causes only fall under a write to this bank's cause offset
        p_cause_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_en && reg_we && (reg_addr == ADDR_W'(4*n)))
            |=> ((cause_all[n] & $past(cause_all[n])) == $past(cause_all[n])));

        // R6: masks move only on a write to their own offset
        p_emask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_en && reg_we && (reg_addr == ADDR_W'(16 + 4*n))) |=> $stable(emask_all[n]));

        p_lmask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_en && reg_we && (reg_addr == ADDR_W'(32 + 4*n))) |=> $stable(lmask_all[n]));

        // R7: a processor with both masks clear raises nothing
        p_irq_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((emask_all[n] | lmask_all[n]) == '0) |=> (irq_grp[n*NG +: NG] == '0));
    end

endmodule

bind gpio_irq_router gpio_irq_router_chk #(
    .NUM_LINES  (NUM_LINES),
    .NUM_CPUS   (NUM_CPUS),
    .GROUP_SIZE (GROUP_SIZE),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_evt  (edge_evt),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_grp   (irq_grp),
    .cause_all (cause_all),
    .emask_all (emask_all),
    .lmask_all (lmask_all)
);

// File: tb/tb_gpio_irq_router.sv
module tb_gpio_irq_router;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] line_level;
    logic [31:0] edge_evt;
    logic        reg_en;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [15:0] irq_grp;

    int checks = 0;
    int errors = 0;

    // bench model, built from the requirements
    logic [31:0] m_cause [4];
    logic [31:0] m_emask [4];
    logic [31:0] m_lmask [4];

    always #5 clk = ~clk;

    gpio_irq_router dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_level (line_level),
        .edge_evt   (edge_evt),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_grp    (irq_grp)
    );

    function automatic logic offset_used(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a < 8'h30);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (!offset_used(a)) return 32'h0;
        case (a[5:4])
            2'd0:    return m_cause[a[3:2]];
            2'd1:    return m_emask[a[3:2]];
            default: return m_lmask[a[3:2]];
        endcase
    endfunction

    function automatic logic [15:0] model_irq();
        logic [15:0] r;
        logic [31:0] pend;
        r = '0;
        for (int n = 0; n < 4; n++) begin
            pend = (line_level & m_lmask[n]) | (m_cause[n] & m_emask[n]);
            for (int g = 0; g < 4; g++) r[n*4+g] = |pend[g*8 +: 8];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus write, optionally with an edge event in the same cycle
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [31:0] evt);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; edge_evt = evt;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; edge_evt = '0;
        if (offset_used(a)) begin
            case (a[5:4])
                2'd0:    m_cause[a[3:2]] = m_cause[a[3:2]] & d;
                2'd1:    m_emask[a[3:2]] = d;
                default: m_lmask[a[3:2]] = d;
            endcase
        end
        for (int n = 0; n < 4; n++) m_cause[n] = m_cause[n] | evt;
    endtask

    task automatic pulse_evt(input logic [31:0] evt);
        edge_evt = evt;
        @(negedge clk);
        edge_evt = '0;
        for (int n = 0; n < 4; n++) m_cause[n] = m_cause[n] | evt;
    endtask

    task automatic bus_read_chk(input string req, input logic [7:0] a);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        chk(req, reg_rdata, model_read(a));
    endtask

    task automatic irq_chk(input string req);
        @(negedge clk);
        chk(req, {16'h0, irq_grp}, {16'h0, model_irq()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        line_level = '0; edge_evt = '0;
        reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int n = 0; n < 4; n++) begin
            m_cause[n] = '0; m_emask[n] = '0; m_lmask[n] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {16'h0, irq_grp}, 32'h0);
        chk("R1 rdata in reset", reg_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", {16'h0, irq_grp}, 32'h0);
        for (int a = 0; a < 48; a += 4) bus_read_chk("R1 register reset value", 8'(a));

        // R2: address map of the masks
        for (int n = 0; n < 4; n++) begin
            bus_write(8'(16 + 4*n), 32'hA500_0000 | 32'(n), '0);
            bus_write(8'(32 + 4*n), 32'h5A00_0000 | 32'(n << 4), '0);
        end
        for (int a = 16; a < 48; a += 4) bus_read_chk("R2 mask readback", 8'(a));
        for (int n = 0; n < 4; n++) begin
            bus_write(8'(16 + 4*n), '0, '0);
            bus_write(8'(32 + 4*n), '0, '0);
        end

        // R3: broadcast event
        pulse_evt(32'h0000_0101);
        for (int n = 0; n < 4; n++) bus_read_chk("R3 event in every bank", 8'(4*n));

        // R4: acknowledge only in bank 1
        bus_write(8'h04, ~32'h1, '0);
        chk("R4 bank1 cleared", model_read(8'h04), 32'h0000_0100);
        for (int n = 0; n < 4; n++) bus_read_chk("R4 own bank only", 8'(4*n));

        // R5: clear and event on the same line in the same cycle
        bus_write(8'h08, 32'h0, 32'h0000_0020);
        bus_read_chk("R5 set wins over clear", 8'h08);
        chk("R5 expected pattern", model_read(8'h08), 32'h0000_0020);

        // R10: masked cause stays readable and silent, then fires
        irq_chk("R10 masked cause silent");
        bus_read_chk("R10 masked cause readable", 8'h0C);
        bus_write(8'h1C, 32'h0000_0100, '0);
        irq_chk("R10 unmask raises group");
        chk("R10 cpu3 group1", {31'h0, irq_grp[13]}, 32'h1);

        // R8: level path follows the line without latching
        bus_write(8'h20, 32'h00FF_0000, '0);
        line_level = 32'h0002_0000;
        irq_chk("R8 level high");
        chk("R8 cpu0 group2 set", {31'h0, irq_grp[2]}, 32'h1);
        line_level = '0;
        irq_chk("R8 level low");
        chk("R8 cpu0 group2 clear", {31'h0, irq_grp[2]}, 32'h0);
        bus_read_chk("R8 cause untouched by level", 8'h00);

        // R9: unused offsets
        bus_write(8'h30, 32'hFFFF_FFFF, '0);
        bus_write(8'h02, 32'h0, '0);
        bus_write(8'h41, 32'h0, '0);
        bus_write(8'hFC, 32'hFFFF_FFFF, '0);
        for (int a = 0; a < 48; a += 4) bus_read_chk("R9 writes ignored", 8'(a));
        bus_read_chk("R9 unused read", 8'h30);
        bus_read_chk("R9 unaligned read", 8'h11);
        bus_read_chk("R9 high read", 8'hC4);

        // R6 and R7: random mix against the model
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            int unsigned cpu;
            op  = $urandom % 6;
            cpu = $urandom % 4;
            case (op)
                0: pulse_evt($urandom & $urandom & $urandom);
                1: bus_write(8'(4*cpu), ~($urandom & $urandom), ($urandom % 4 == 0) ? ($urandom & $urandom) : 32'h0);
                2: bus_write(8'(16 + 4*cpu), $urandom & $urandom, '0);
                3: bus_write(8'(32 + 4*cpu), $urandom & $urandom & $urandom, '0);
                4: line_level = $urandom & $urandom;
                default: begin
                    logic [7:0] a;
                    a = ($urandom % 2 == 1) ? 8'(($urandom % 16) * 4) : 8'($urandom);
                    bus_read_chk("R6 random readback", a);
                end
            endcase
            irq_chk("R7 random group outputs");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule